// File: doc/BRIEF.md
# Output Voltage Reference Slew Sequencer

This block owns the digital code of a 9-bit voltage-reference DAC that sets a supply's output voltage. When a new target code arrives with a one-cycle start strobe, the block does not jump to it. First it turns off the synchronous-rectifier enable and holds the code for a lead time. It then walks the code one unit at a time, one step per fixed interval, until the code equals the target. Once the code lands, it keeps the rectifier off for a long settle delay before turning it back on.

The lead time is chosen by direction. A rising move uses a long lead, around 5 ms in the intended setting. A falling move uses a short lead, around 200 µs. A falling move also drives the bleeder enable for as long as the code is stepping, so that the output capacitor is discharged along with the reference. A step of one code every 750 µs is about 5 mV on a 2.7 V full scale, which keeps a 20 V to 5 V move well inside 275 ms.

The lead, step and settle intervals are static inputs counted in clock cycles. The default settle delay is 300 ms. After reset the code sits at a parameter value that gives 5 V at the output.

Top module: `vslew_seq`

## Requirements
- R1: After reset, code_o equals the RESET_CODE parameter (default 118), busy_o is 0, rect_en_o is 1 and bleed_en_o is 0.
- R2: A start strobe whose target_i equals the present code_o, while the block is idle, is ignored. busy_o stays 0 and rect_en_o stays 1.
- R3: A start strobe with a different target, sampled at clock edge E, makes busy_o 1 and rect_en_o 0 from edge E. code_o then holds for the lead time: lead_up_i cycles if the target is above code_o, lead_dn_i cycles otherwise.
- R4: After the lead time, code_o moves by exactly one toward the target every step_i cycles. The first step comes step_i cycles after the lead time ends. The code changes only while busy_o is 1 and rect_en_o is 0.
- R5: bleed_en_o is 1 only while the code is stepping downward: from the end of the lead time of a falling move until the edge at which the code reaches the target. It is 0 during every lead time and during rising moves.
- R6: From the edge at which code_o reaches the target, busy_o stays 1 and rect_en_o stays 0 for settle_i cycles. After that, busy_o falls and rect_en_o rises on the same edge.
- R7: A new target strobed during stepping continues from the present code at the existing step cadence, with no new lead time. A new target equal to the present code ends stepping at once and starts the settle delay.
- R8: A new target strobed during the lead time replaces the target without restarting or re-choosing the lead time. Stepping after the lead time goes toward the newest target.
- R9: A new target that differs from the present code and is strobed during the settle delay restarts stepping at once, with the first step step_i cycles later and no lead time. rect_en_o stays 0.
- R10: A lead, step or settle value of 0 behaves as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that accepts target_i |
| target_i | input | CODE_W (9) | Requested reference code |
| lead_up_i | input | DLY_W (20) | Lead cycles before a rising move |
| lead_dn_i | input | DLY_W (20) | Lead cycles before a falling move |
| step_i | input | STEP_W (16) | Cycles between code steps |
| settle_i | input | SETTLE_W (24) | Cycles the rectifier stays off after landing |
| code_o | output | CODE_W (9) | Reference DAC code |
| busy_o | output | 1 | A move or its settle delay is in progress |
| rect_en_o | output | 1 | Synchronous-rectifier enable |
| bleed_en_o | output | 1 | Output bleeder enable |

## Verification
A wrong phase or a corrupted interval count shows up first as a code change on the wrong cycle. The scoreboard pins every code change to an exact cycle, so an error of even one cycle in the lead, step or settle count is caught at the next step. A stale or wrong held target shows as steps in the wrong direction, or as a ramp that overshoots or stops short, within one step interval. A wrong phase decode shows on rect_en_o, busy_o or bleed_en_o at the cycles sampled around each phase boundary: before the lead time ends, before the first falling step, and one cycle before and after the settle delay runs out.

// File: rtl/vslew_pkg.sv
package vslew_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LEAD   = 2'd1,
      ST_RAMP   = 2'd2,
      ST_SETTLE = 2'd3
   } vslew_state_e;

endpackage

// File: rtl/vslew_timer.sv
module vslew_timer #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   input  logic             run_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   // a loaded value of 0 or 1 expires on the next run cycle
   assign expire_o = (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= val_i;
      else if (run_i && !expire_o)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   // R10: zero behaves as a single cycle
   p_zero_is_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && val_i == '0) |=> expire_o);

endmodule

// File: rtl/vslew_code_reg.sv
module vslew_code_reg #(
   parameter int CODE_W     = 9,
   parameter int RESET_CODE = 118
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_up_i,
   input  logic              step_dn_i,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);
   localparam logic [CODE_W-1:0] INIT = CODE_W'(RESET_CODE);

   if (RESET_CODE < 0 || RESET_CODE >= (1 << CODE_W)) begin : g_bad_reset
      $error("RESET_CODE does not fit in CODE_W bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_o <= INIT;
      else if (step_up_i)
         code_o <= code_o + ONE;
      else if (step_dn_i)
         code_o <= code_o - ONE;
   end

   // R4: both directions are never requested together
   p_one_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up_i && step_dn_i));

   // R4: code moves by one unit at most per cycle
   p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> (code_o == $past(code_o) + ONE || code_o == $past(code_o) - ONE));

endmodule

// File: rtl/vslew_fsm.sv
module vslew_fsm
   import vslew_pkg::*;
#(
   parameter int CODE_W     = 9,
   parameter int CNT_W      = 24,
   parameter int DLY_W      = 20,
   parameter int STEP_W     = 16,
   parameter int SETTLE_W   = 24,
   parameter int RESET_CODE = 118
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CODE_W-1:0]   target_i,
   input  logic [CODE_W-1:0]   code_i,
   input  logic [DLY_W-1:0]    lead_up_i,
   input  logic [DLY_W-1:0]    lead_dn_i,
   input  logic [STEP_W-1:0]   step_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                tmr_expire_i,
   output logic                tmr_load_o,
   output logic [CNT_W-1:0]    tmr_val_o,
   output logic                tmr_run_o,
   output logic                step_up_o,
   output logic                step_dn_o,
   output logic                busy_o,
   output logic                rect_en_o,
   output logic                bleed_en_o
);

   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   vslew_state_e      state_q, state_d;
   logic [CODE_W-1:0] tgt_q, tgt_d, tgt_eff;
   logic              go_up, go_dn, last_step;
   logic [CNT_W-1:0]  up_ext, dn_ext, step_ext, settle_ext;

   assign up_ext     = CNT_W'(lead_up_i);
   assign dn_ext     = CNT_W'(lead_dn_i);
   assign step_ext   = CNT_W'(step_i);
   assign settle_ext = CNT_W'(settle_i);

   // a strobe in the same cycle takes effect for this cycle's decision
   assign tgt_eff   = start_i ? target_i : tgt_q;
   assign go_up     = (tgt_eff > code_i);
   assign go_dn     = (tgt_eff < code_i);
   assign last_step = (go_up && tgt_eff == code_i + ONE) ||
                      (go_dn && tgt_eff == code_i - ONE);

   always_comb begin
      state_d    = state_q;
      tgt_d      = tgt_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      tmr_run_o  = 1'b0;
      step_up_o  = 1'b0;
      step_dn_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i && go_up != go_dn) begin
               tgt_d      = target_i;
               state_d    = ST_LEAD;
               tmr_load_o = 1'b1;
               tmr_val_o  = go_up ? up_ext : dn_ext;
            end
         end
         ST_LEAD: begin
            if (start_i)
               tgt_d = target_i;
            tmr_run_o = 1'b1;
            if (tmr_expire_i) begin
               tmr_load_o = 1'b1;
               if (!go_up && !go_dn) begin
                  state_d   = ST_SETTLE;
                  tmr_val_o = settle_ext;
               end else begin
                  state_d   = ST_RAMP;
                  tmr_val_o = step_ext;
               end
            end
         end
         ST_RAMP: begin
            if (start_i)
               tgt_d = target_i;
            if (!go_up && !go_dn) begin
               state_d    = ST_SETTLE;
               tmr_load_o = 1'b1;
               tmr_val_o  = settle_ext;
            end else begin
               tmr_run_o = 1'b1;
               if (tmr_expire_i) begin
                  step_up_o  = go_up;
                  step_dn_o  = go_dn;
                  tmr_load_o = 1'b1;
                  if (last_step) begin
                     state_d   = ST_SETTLE;
                     tmr_val_o = settle_ext;
                  end else begin
                     tmr_val_o = step_ext;
                  end
               end
            end
         end
         ST_SETTLE: begin
            if (start_i && target_i != code_i) begin
               tgt_d      = target_i;
               state_d    = ST_RAMP;
               tmr_load_o = 1'b1;
               tmr_val_o  = step_ext;
            end else begin
               tmr_run_o = 1'b1;
               if (tmr_expire_i)
                  state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tgt_q   <= CODE_W'(RESET_CODE);
      end else begin
         state_q <= state_d;
         tgt_q   <= tgt_d;
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign rect_en_o  = (state_q == ST_IDLE);
   assign bleed_en_o = (state_q == ST_RAMP) && (tgt_q < code_i);

   // R2: an equal target leaves the block idle
   p_equal_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && start_i && target_i == code_i) |=> rect_en_o);

   // R6: the rectifier returns only out of the settle phase
   p_rect_after_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rect_en_o) |-> $past(state_q) == ST_SETTLE);

   // R6: when idle the held target and the code agree
   p_idle_on_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rect_en_o |-> tgt_q == code_i);

endmodule

// File: rtl/vslew_seq.sv
module vslew_seq #(
   parameter int CODE_W     = 9,
   parameter int DLY_W      = 20,
   parameter int STEP_W     = 16,
   parameter int SETTLE_W   = 24,
   parameter int RESET_CODE = 118
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [CODE_W-1:0]   target_i,
   input  logic [DLY_W-1:0]    lead_up_i,
   input  logic [DLY_W-1:0]    lead_dn_i,
   input  logic [STEP_W-1:0]   step_i,
   input  logic [SETTLE_W-1:0] settle_i,
   output logic [CODE_W-1:0]   code_o,
   output logic                busy_o,
   output logic                rect_en_o,
   output logic                bleed_en_o
);

   localparam int W_A   = (DLY_W > STEP_W) ? DLY_W : STEP_W;
   localparam int CNT_W = (W_A > SETTLE_W) ? W_A : SETTLE_W;

   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code
      $error("CODE_W must lie in 2..16");
   end
   if (DLY_W < 1 || STEP_W < 1 || SETTLE_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("interval widths must lie in 1..32");
   end

   logic             tmr_load, tmr_run, tmr_expire;
   logic [CNT_W-1:0] tmr_val;
   logic             step_up, step_dn;

   vslew_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .val_i    (tmr_val),
      .run_i    (tmr_run),
      .expire_o (tmr_expire)
   );

   vslew_code_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_code (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_up_i (step_up),
      .step_dn_i (step_dn),
      .code_o    (code_o)
   );

   vslew_fsm #(
      .CODE_W(CODE_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .STEP_W(STEP_W),
      .SETTLE_W(SETTLE_W), .RESET_CODE(RESET_CODE)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .target_i     (target_i),
      .code_i       (code_o),
      .lead_up_i    (lead_up_i),
      .lead_dn_i    (lead_dn_i),
      .step_i       (step_i),
      .settle_i     (settle_i),
      .tmr_expire_i (tmr_expire),
      .tmr_load_o   (tmr_load),
      .tmr_val_o    (tmr_val),
      .tmr_run_o    (tmr_run),
      .step_up_o    (step_up),
      .step_dn_o    (step_dn),
      .busy_o       (busy_o),
      .rect_en_o    (rect_en_o),
      .bleed_en_o   (bleed_en_o)
   );

   // R4: the code moves only with the rectifier off and a move in progress
   p_move_rect_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o) |-> (!rect_en_o && busy_o));

   // R5: while the bleeder is on, any code change is downward
   p_bleed_downward_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bleed_en_o && !$stable(code_o)) |-> code_o < $past(code_o));

   // R5: the bleeder never runs with the rectifier enabled
   p_bleed_rect_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bleed_en_o |-> !rect_en_o);

endmodule

// File: tb/vslew_seq_test.sv
module vslew_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [8:0]  target = '0;
   logic [19:0] lead_up = 20'd5;
   logic [19:0] lead_dn = 20'd3;
   logic [15:0] step = 16'd4;
   logic [23:0] settle = 24'd10;
   logic [8:0]  code_o;
   logic        busy_o, rect_en_o, bleed_en_o;

   vslew_seq uut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .target_i (target),
      .lead_up_i (lead_up), .lead_dn_i (lead_dn), .step_i (step), .settle_i (settle),
      .code_o (code_o), .busy_o (busy_o), .rect_en_o (rect_en_o), .bleed_en_o (bleed_en_o)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_bad = 0;

   int    exp_cyc[$];
   int    exp_code[$];
   string exp_tag[$];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   // driver side of the scoreboard: one item per expected code change
   task automatic push_steps(input string tag, input int first, input int from, input int to, input int s);
      int n = (to > from) ? to - from : from - to;
      for (int k = 1; k <= n; k++) begin
         exp_cyc.push_back(first + s * (k - 1));
         exp_code.push_back((to > from) ? from + k : from - k);
         exp_tag.push_back(tag);
      end
   endtask

   task automatic launch(input int t, output int e);
      start  = 1'b1;
      target = t[8:0];
      e      = cyc + 1;
      @(negedge clk);
      start  = 1'b0;
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // monitor side: pop and compare on each observed code change
   int    m_cyc, m_code;
   string m_tag;
   logic [8:0] prev_code;
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_code = code_o;
      end else if (code_o != prev_code) begin
         if (exp_cyc.size() == 0) begin
            check("R4 unexpected step", int'(code_o), int'(prev_code));
         end else begin
            m_cyc  = exp_cyc.pop_front();
            m_code = exp_code.pop_front();
            m_tag  = exp_tag.pop_front();
            check({m_tag, " step cycle"}, cyc, m_cyc);
            check({m_tag, " step code"}, int'(code_o), m_code);
         end
         prev_code = code_o;
      end
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      int e, r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 code", int'(code_o), 118);
      check("R1 busy", int'(busy_o), 0);
      check("R1 rect", int'(rect_en_o), 1);
      check("R1 bleed", int'(bleed_en_o), 0);

      // R2 equal target is ignored
      launch(118, e);
      check("R2 busy", int'(busy_o), 0);
      check("R2 rect", int'(rect_en_o), 1);
      wait_cyc(e + 3);
      check("R2 busy later", int'(busy_o), 0);

      // R3/R4/R6 rising move 118 -> 121
      launch(121, e);
      push_steps("R4 rise", e + 9, 118, 121, 4);
      check("R3 busy", int'(busy_o), 1);
      check("R3 rect", int'(rect_en_o), 0);
      wait_cyc(e + 8);
      check("R3 code held in lead", int'(code_o), 118);
      wait_cyc(e + 10);
      check("R5 no bleed rising", int'(bleed_en_o), 0);
      wait_cyc(e + 26);
      check("R6 rect in settle", int'(rect_en_o), 0);
      check("R6 busy in settle", int'(busy_o), 1);
      wait_cyc(e + 27);
      check("R6 rect back", int'(rect_en_o), 1);
      check("R6 busy done", int'(busy_o), 0);

      // R5 falling move 121 -> 118
      launch(118, e);
      push_steps("R4 fall", e + 7, 121, 118, 4);
      wait_cyc(e + 2);
      check("R5 no bleed in lead", int'(bleed_en_o), 0);
      wait_cyc(e + 3);
      check("R5 bleed on", int'(bleed_en_o), 1);
      wait_cyc(e + 14);
      check("R5 bleed held", int'(bleed_en_o), 1);
      wait_cyc(e + 15);
      check("R5 bleed off at target", int'(bleed_en_o), 0);
      wait_cyc(e + 25);
      check("R6 fall done", int'(busy_o), 0);

      // R7 retarget mid-ramp, reversing 118 -> 130 -> 115
      launch(130, e);
      push_steps("R7 up", e + 9, 118, 120, 4);
      wait_cyc(e + 14);
      launch(115, r);
      push_steps("R7 reverse", e + 17, 120, 115, 4);
      wait_cyc(e + 42);
      check("R7 busy before end", int'(busy_o), 1);
      wait_cyc(e + 43);
      check("R7 busy end", int'(busy_o), 0);
      check("R7 rect end", int'(rect_en_o), 1);

      // R7 retarget equal to present code
      launch(120, e);
      push_steps("R7 eq", e + 9, 115, 117, 4);
      wait_cyc(e + 14);
      launch(117, r);
      check("R7 eq rect", int'(rect_en_o), 0);
      wait_cyc(r + 9);
      check("R7 eq settling", int'(busy_o), 1);
      wait_cyc(r + 10);
      check("R7 eq done", int'(busy_o), 0);
      check("R7 eq code", int'(code_o), 117);

      // R8 retarget during lead: rising lead kept, ramp goes down
      launch(125, e);
      wait_cyc(e + 1);
      launch(110, r);
      push_steps("R8", e + 9, 117, 110, 4);
      wait_cyc(e + 4);
      check("R8 still in lead", int'(bleed_en_o), 0);
      wait_cyc(e + 5);
      check("R8 ramp down", int'(bleed_en_o), 1);
      wait_cyc(e + 42);
      check("R8 busy", int'(busy_o), 1);
      wait_cyc(e + 43);
      check("R8 done", int'(busy_o), 0);

      // R9 retarget during settle
      launch(112, e);
      push_steps("R9 up", e + 9, 110, 112, 4);
      wait_cyc(e + 16);
      launch(108, r);
      push_steps("R9 resume", r + 4, 112, 108, 4);
      check("R9 rect off", int'(rect_en_o), 0);
      wait_cyc(r + 25);
      check("R9 busy", int'(busy_o), 1);
      wait_cyc(r + 26);
      check("R9 done", int'(busy_o), 0);

      // R10 zero intervals behave as one cycle
      lead_up = '0;
      step    = '0;
      settle  = '0;
      @(negedge clk);
      launch(110, e);
      push_steps("R10", e + 2, 108, 110, 1);
      wait_cyc(e + 3);
      check("R10 busy", int'(busy_o), 1);
      wait_cyc(e + 4);
      check("R10 done", int'(busy_o), 0);
      check("R10 rect", int'(rect_en_o), 1);

      repeat (3) @(negedge clk);
      check("R4 all steps seen", exp_cyc.size(), 0);
      summary();
      $finish;
   end

endmodule